// File: doc/BRIEF.md
# Pointer-Register Address Generator

This block computes the data-space address for loads and stores that go through one of three 16-bit pointer registers, named X, Y and Z here. It also produces the address for program-memory reads and for stack pushes and pops. The pointer values come in from the register file. The block sends back the updated pointer value, a write-back enable and the index of the pointer to write. The stack pointer is the only state the block keeps.

Each request is held by the requester until `mem_ready` is high. A memory path that is slow, such as one through a nonvolatile-memory controller, holds `mem_ready` low for one or more cycles. While `mem_ready` is low the block raises `stall`. It writes back no pointer and leaves the stack pointer where it is. The address outputs follow the inputs combinationally, so they stay steady for as long as the request is held.

Top module: `ptr_agu`

## Requirements
- R1: Pointer access (`op`=1) with `mode`=0 (plain) puts the selected pointer on `acc_addr` and never raises `ptr_we`. Pointer codes in `ptr_sel` are 0=X, 1=Y and 2=Z.
- R2: `mode`=1 (post-increment) uses the current pointer as `acc_addr`. `ptr_wdata` is that pointer plus one, modulo 2^16.
- R3: `mode`=2 (pre-decrement) uses the pointer minus one, modulo 2^16, as `acc_addr`. `ptr_wdata` carries the same value.
- R4: `mode`=3 (displacement) on Y or Z gives `acc_addr` equal to the pointer plus the unsigned 6-bit `disp` (0..63), modulo 2^16. `ptr_we` stays low.
- R5: Two pointer requests are rejected: displacement on X, and a request with `ptr_sel`=3. For both, `acc_valid`, `stall` and `ptr_we` stay low and the stack pointer is unchanged.
- R6: A legal request with `mem_ready` low raises `stall`, keeps `ptr_we` low and holds `sp_value`. Write-back and stack updates happen only in the cycle in which `mem_ready` is high. When `ptr_we` is high, `ptr_we_sel` equals `ptr_sel`.
- R7: A program-memory read (`op`=4) uses Z as `acc_addr` whatever `ptr_sel` and `mode` are. It raises `acc_pmem`, which marks the result for register 0, and writes back no pointer.
- R8: A push (`op`=2) addresses the current stack pointer. In the ready cycle the stack pointer then decrements by one.
- R9: A pop (`op`=3) addresses the stack pointer plus one. In the ready cycle the stack pointer increments by one.
- R10: `op` codes 0, 5, 6 and 7 make no access. `acc_valid`, `stall` and `ptr_we` stay low and `sp_value` is unchanged.
- R11: After reset `sp_value` equals `SP_INIT`, which defaults to 0x10FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 3 | Request kind: 0 none, 1 pointer, 2 push, 3 pop, 4 program read |
| ptr_sel | input | 2 | Pointer select: 0 X, 1 Y, 2 Z |
| mode | input | 2 | Addressing mode: 0 plain, 1 post-increment, 2 pre-decrement, 3 displacement |
| disp | input | 6 | Unsigned displacement |
| ptr_x | input | 16 | Current X value |
| ptr_y | input | 16 | Current Y value |
| ptr_z | input | 16 | Current Z value |
| mem_ready | input | 1 | Memory completes the access this cycle |
| acc_valid | output | 1 | A legal access is presented |
| acc_addr | output | 16 | Effective address |
| acc_pmem | output | 1 | Access targets program memory, result to register 0 |
| stall | output | 1 | Legal access waiting for ready |
| ptr_we | output | 1 | Pointer write-back enable |
| ptr_we_sel | output | 2 | Pointer to write back |
| ptr_wdata | output | 16 | Updated pointer value |
| sp_value | output | 16 | Current stack pointer |

## Verification
The stack pointer is the only internal state. If it holds a wrong value, the error shows on `sp_value` right after the clock edge that wrongly moved or held it. It also shows on `acc_addr` at the next push or pop. A wrong decision on a pointer update shows in the same cycle on `ptr_we` or `ptr_wdata`. The register file would keep that wrong value, so a single bad update causes later errors. The reference model therefore compares every output on every cycle, including cycles where ready is low and cycles with rejected codes.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [1:0] {
    PM_PLAIN   = 2'd0,
    PM_POSTINC = 2'd1,
    PM_PREDEC  = 2'd2,
    PM_DISP    = 2'd3
  } pmode_e;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_PTR  = 3'd1,
    OP_PUSH = 3'd2,
    OP_POP  = 3'd3,
    OP_PMEM = 3'd4
  } op_e;

  localparam logic [1:0] SEL_X = 2'd0;
  localparam logic [1:0] SEL_Y = 2'd1;
  localparam logic [1:0] SEL_Z = 2'd2;

endpackage

// File: rtl/agu_ptr_sel.sv
module agu_ptr_sel #(
  parameter int AW = 16
) (
  input  logic [1:0]    sel,
  input  logic [AW-1:0] px,
  input  logic [AW-1:0] py,
  input  logic [AW-1:0] pz,
  output logic [AW-1:0] pval,
  output logic          sel_ok
);
  import agu_pkg::*;

  always_comb begin
    pval   = '0;
    sel_ok = 1'b1;
    case (sel)
      SEL_X:   pval = px;
      SEL_Y:   pval = py;
      SEL_Z:   pval = pz;
      default: sel_ok = 1'b0;
    endcase
  end

endmodule

// File: rtl/agu_ptr_calc.sv
module agu_ptr_calc #(
  parameter int AW = 16,
  parameter int QW = 6
) (
  input  logic [AW-1:0] pval,
  input  logic [1:0]    mode,
  input  logic [QW-1:0] disp,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] wdata,
  output logic          upd,
  output logic          uses_disp
);
  import agu_pkg::*;

  localparam logic [AW-1:0] ONE = AW'(1);

  function automatic logic [AW-1:0] f_step_up(input logic [AW-1:0] p);
    return p + ONE;
  endfunction

  function automatic logic [AW-1:0] f_step_down(input logic [AW-1:0] p);
    return p - ONE;
  endfunction

  function automatic logic [AW-1:0] f_offset(input logic [AW-1:0] p,
                                             input logic [QW-1:0] q);
    return p + {{(AW-QW){1'b0}}, q};
  endfunction

  pmode_e m;
  assign m = pmode_e'(mode);

  always_comb begin
    addr      = pval;
    wdata     = pval;
    upd       = 1'b0;
    uses_disp = 1'b0;
    case (m)
      PM_PLAIN: ;
      PM_POSTINC: begin
        wdata = f_step_up(pval);
        upd   = 1'b1;
      end
      PM_PREDEC: begin
        wdata = f_step_down(pval);
        addr  = wdata;
        upd   = 1'b1;
      end
      default: begin
        addr      = f_offset(pval, disp);
        uses_disp = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/agu_stack.sv
module agu_stack #(
  parameter int              AW      = 16,
  parameter logic [AW-1:0]   SP_INIT = AW'(16'h10FF)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_fire,
  input  logic          pop_fire,
  output logic [AW-1:0] sp,
  output logic [AW-1:0] push_addr,
  output logic [AW-1:0] pop_addr
);
  localparam logic [AW-1:0] ONE = AW'(1);

  function automatic logic [AW-1:0] f_sp_up(input logic [AW-1:0] s);
    return s + ONE;
  endfunction

  function automatic logic [AW-1:0] f_sp_down(input logic [AW-1:0] s);
    return s - ONE;
  endfunction

  assign push_addr = sp;
  assign pop_addr  = f_sp_up(sp);

  always_ff @(posedge clk) begin
    if (!rst_n)         sp <= SP_INIT;
    else if (push_fire) sp <= f_sp_down(sp);
    else if (pop_fire)  sp <= f_sp_up(sp);
  end

endmodule

// File: rtl/ptr_agu.sv
module ptr_agu #(
  parameter int            AW      = 16,
  parameter int            QW      = 6,
  parameter logic [AW-1:0] SP_INIT = AW'(16'h10FF)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    op,
  input  logic [1:0]    ptr_sel,
  input  logic [1:0]    mode,
  input  logic [QW-1:0] disp,
  input  logic [AW-1:0] ptr_x,
  input  logic [AW-1:0] ptr_y,
  input  logic [AW-1:0] ptr_z,
  input  logic          mem_ready,
  output logic          acc_valid,
  output logic [AW-1:0] acc_addr,
  output logic          acc_pmem,
  output logic          stall,
  output logic          ptr_we,
  output logic [1:0]    ptr_we_sel,
  output logic [AW-1:0] ptr_wdata,
  output logic [AW-1:0] sp_value
);
  import agu_pkg::*;

  op_e op_k;
  assign op_k = op_e'(op);

  logic is_ptr, is_push, is_pop, is_pmem;
  always_comb begin
    is_ptr  = 1'b0;
    is_push = 1'b0;
    is_pop  = 1'b0;
    is_pmem = 1'b0;
    case (op_k)
      OP_PTR:  is_ptr  = 1'b1;
      OP_PUSH: is_push = 1'b1;
      OP_POP:  is_pop  = 1'b1;
      OP_PMEM: is_pmem = 1'b1;
      default: ;
    endcase
  end

  logic [1:0] eff_sel, eff_mode;
  assign eff_sel  = is_pmem ? SEL_Z : ptr_sel;
  assign eff_mode = is_pmem ? PM_PLAIN : mode;

  logic [AW-1:0] pval;
  logic          sel_ok;
  agu_ptr_sel #(.AW(AW)) u_sel (
    .sel(eff_sel), .px(ptr_x), .py(ptr_y), .pz(ptr_z),
    .pval(pval), .sel_ok(sel_ok)
  );

  logic [AW-1:0] calc_addr, calc_wdata;
  logic          calc_upd, uses_disp;
  agu_ptr_calc #(.AW(AW), .QW(QW)) u_calc (
    .pval(pval), .mode(eff_mode), .disp(disp),
    .addr(calc_addr), .wdata(calc_wdata),
    .upd(calc_upd), .uses_disp(uses_disp)
  );

  // named internal events
  logic x_disp_reject, ptr_legal, fire, push_fire, pop_fire;
  assign x_disp_reject = (eff_sel == SEL_X) && uses_disp;
  assign ptr_legal     = is_ptr && sel_ok && !x_disp_reject;
  assign acc_valid     = ptr_legal || is_push || is_pop || is_pmem;
  assign fire          = acc_valid && mem_ready;
  assign push_fire     = fire && is_push;
  assign pop_fire      = fire && is_pop;

  logic [AW-1:0] push_addr, pop_addr;
  agu_stack #(.AW(AW), .SP_INIT(SP_INIT)) u_stack (
    .clk(clk), .rst_n(rst_n),
    .push_fire(push_fire), .pop_fire(pop_fire),
    .sp(sp_value), .push_addr(push_addr), .pop_addr(pop_addr)
  );

  always_comb begin
    acc_addr = '0;
    if (is_push)        acc_addr = push_addr;
    else if (is_pop)    acc_addr = pop_addr;
    else if (acc_valid) acc_addr = calc_addr;
  end

  assign acc_pmem   = is_pmem;
  assign stall      = acc_valid && !mem_ready;
  assign ptr_we     = fire && ptr_legal && calc_upd;
  assign ptr_we_sel = ptr_sel;
  assign ptr_wdata  = calc_wdata;

endmodule

// File: rtl/ptr_agu_chk.sv
module ptr_agu_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode,
  input logic          acc_valid,
  input logic [AW-1:0] acc_addr,
  input logic          stall,
  input logic          ptr_we,
  input logic [AW-1:0] ptr_wdata,
  input logic [AW-1:0] sp_value,
  input logic          push_fire,
  input logic          pop_fire
);
  localparam logic [AW-1:0] ONE = AW'(1);

  a_r6_no_we_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !ptr_we);

  a_r6_stall_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> acc_valid);

  a_r6_sp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_fire || pop_fire) |=> $stable(sp_value));

  a_r8_push_step: assert property (@(posedge clk) disable iff (!rst_n)
    push_fire |=> sp_value == $past(sp_value) - ONE);

  a_r8_push_addr: assert property (@(posedge clk) disable iff (!rst_n)
    push_fire |-> acc_addr == sp_value);

  a_r9_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
    pop_fire |=> sp_value == $past(sp_value) + ONE);

  a_r2_postinc_value: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_we && mode == 2'd1) |-> ptr_wdata == acc_addr + ONE);

  a_r3_predec_same: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_we && mode == 2'd2) |-> ptr_wdata == acc_addr);

endmodule

bind ptr_agu ptr_agu_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .acc_valid(acc_valid),
  .acc_addr(acc_addr), .stall(stall), .ptr_we(ptr_we),
  .ptr_wdata(ptr_wdata), .sp_value(sp_value),
  .push_fire(push_fire), .pop_fire(pop_fire)
);

// File: tb/test_ptr_agu.sv
module test_ptr_agu;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op = '0;
  logic [1:0]  ptr_sel = '0;
  logic [1:0]  mode = '0;
  logic [5:0]  disp = '0;
  logic [15:0] ptr_x = '0, ptr_y = '0, ptr_z = '0;
  logic        mem_ready = 1'b0;
  logic        acc_valid, acc_pmem, stall, ptr_we;
  logic [15:0] acc_addr, ptr_wdata, sp_value;
  logic [1:0]  ptr_we_sel;

  always #10 clk = ~clk;

  ptr_agu i_ptr_agu (
    .clk(clk), .rst_n(rst_n), .op(op), .ptr_sel(ptr_sel), .mode(mode),
    .disp(disp), .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z),
    .mem_ready(mem_ready), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_pmem(acc_pmem), .stall(stall), .ptr_we(ptr_we),
    .ptr_we_sel(ptr_we_sel), .ptr_wdata(ptr_wdata), .sp_value(sp_value)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  int model_sp = 'h10FF;

  task automatic chk(input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, compare mid-low phase, advance model
  task automatic step(input int o, input int s, input int m, input int d,
                      input bit rdy);
    int ev, ea, epm, ewe, ewd, upd, p;
    string tag;
    @(negedge clk);
    op = 3'(o); ptr_sel = 2'(s); mode = 2'(m); disp = 6'(d); mem_ready = rdy;
    #5;
    ev = 0; ea = 0; epm = 0; ewd = 0; upd = 0; tag = "R10";
    if (o == 1) begin
      p = (s == 0) ? int'(ptr_x) : (s == 1) ? int'(ptr_y) : int'(ptr_z);
      if (s == 3 || (s == 0 && m == 3)) tag = "R5";
      else begin
        ev = 1;
        case (m)
          0: begin tag = "R1"; ea = p; end
          1: begin tag = "R2"; ea = p; ewd = (p + 1) % 65536; upd = 1; end
          2: begin tag = "R3"; ewd = (p + 65535) % 65536; ea = ewd; upd = 1; end
          default: begin tag = "R4"; ea = (p + d) % 65536; end
        endcase
      end
    end else if (o == 2) begin tag = "R8"; ev = 1; ea = model_sp; end
    else if (o == 3) begin tag = "R9"; ev = 1; ea = (model_sp + 1) % 65536; end
    else if (o == 4) begin tag = "R7"; ev = 1; epm = 1; ea = int'(ptr_z); end
    ewe = ev & rdy & upd;
    chk(tag, "acc_valid", int'(acc_valid), ev);
    chk(tag, "acc_pmem", int'(acc_pmem), epm);
    chk(tag, "sp_value", int'(sp_value), model_sp);
    if (ev != 0) chk(tag, "acc_addr", int'(acc_addr), ea);
    chk((ev != 0 && !rdy) ? "R6" : tag, "stall", int'(stall), ev & !rdy);
    chk((ev != 0 && !rdy) ? "R6" : tag, "ptr_we", int'(ptr_we), ewe);
    if (ewe != 0) begin
      chk(tag, "ptr_wdata", int'(ptr_wdata), ewd);
      chk("R6", "ptr_we_sel", int'(ptr_we_sel), s);
    end
    if (ev != 0 && rdy) begin
      if (o == 2) model_sp = (model_sp + 65535) % 65536;
      if (o == 3) model_sp = (model_sp + 1) % 65536;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #5;
    chk("R11", "sp_value", int'(sp_value), 'h10FF);
    chk("R11", "acc_valid", int'(acc_valid), 0);
    ptr_x = 16'h1234; ptr_y = 16'hFFFF; ptr_z = 16'h0000;
    step(1, 0, 0, 0, 1);   // R1 plain on X
    step(1, 1, 1, 0, 1);   // R2 post-inc wraps to 0
    step(1, 2, 2, 0, 1);   // R3 pre-dec wraps to FFFF
    step(1, 2, 1, 0, 0);   // R6 no write-back while waiting
    step(1, 1, 3, 63, 1);  // R4 displacement wraps
    ptr_z = 16'h2000;
    step(1, 2, 3, 17, 1);  // R4 on Z
    step(1, 0, 3, 5, 1);   // R5 X displacement rejected
    step(1, 3, 1, 0, 1);   // R5 select code 3 rejected
    step(4, 1, 2, 9, 1);   // R7 program read uses Z
    step(2, 0, 0, 0, 0);   // R6 push waits, sp holds
    step(2, 0, 0, 0, 1);   // R8 push
    step(2, 0, 0, 0, 1);   // R8 push again
    step(3, 0, 0, 0, 1);   // R9 pop
    step(6, 0, 0, 0, 1);   // R10 unused code
    step(0, 0, 0, 0, 1);   // R10 idle
    for (int i = 0; i < 600; i++) begin
      ptr_x = 16'($urandom); ptr_y = 16'($urandom);
      ptr_z = ($urandom_range(0, 3) == 0) ? 16'hFFFF : 16'($urandom);
      step(int'($urandom_range(0, 7)), int'($urandom_range(0, 3)),
           int'($urandom_range(0, 3)), int'($urandom_range(0, 63)),
           $urandom_range(0, 9) < 7);
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule